// File: doc/BRIEF.md
# Clock Output Divider Network

This block is the digital back end of a zero-delay clock buffer. A fast oscillator clock, or, in bypass test mode, one of two reference clocks, drives a small divider tree. The tree makes five identical main clocks, one inverted main clock, a double-rate clock and a half-rate clock. The phase detector, charge pump, filter, oscillator and lock detector sit outside the block. The lock flag only passes through.

An external loop closes around the block by returning one of its outputs to the phase detector. Returning the half-rate output makes the main clocks run at twice the reference. Returning a main output makes them run at the reference rate. Returning the double-rate output makes them run at half the reference. An optional pre-divider halves the oscillator before the tree. The active-low `oe_rst_n` input works asynchronously. While it is low, it clears every divider flop and drops every per-output enable, which stands in for a high-impedance output. It has no effect on the lock flag.

The main and half-rate clocks come from a four-state phase machine. Its states are PH_IDLE (main 0, half 0), PH_BOTH_HI (main 1, half 1), PH_HALF_HI (main 0, half 1) and PH_MAIN_HI (main 1, half 0). It steps PH_IDLE to PH_BOTH_HI to PH_HALF_HI to PH_MAIN_HI and back to PH_IDLE, one step on each rising edge of the internal double-rate node. Reset forces the machine to PH_IDLE.

Top module: `clk_fanout_divider`

## Requirements
- R1: `ref_sel` = 0 picks `ref_clk0` and `ref_sel` = 1 picks `ref_clk1` as the selected reference.
- R2: With `pll_on` = 1 and `prediv_en` = 0, each output changes on osc rising edges. `dbl_clk` toggles on every such edge, `main_clk` runs at osc/4 and `half_clk` runs at osc/8. After release, all three rise together on the first osc rising edge.
- R3: With `pll_on` = 1 and `prediv_en` = 1, one extra divide-by-two stage comes first. `dbl_clk` runs at osc/4, `main_clk` at osc/8 and `half_clk` at osc/16. After release, all three rise on the first osc rising edge.
- R4: All bits of `main_clk` are equal at all times, and `inv_clk` is their complement.
- R5: `half_clk` changes only at the instant `main_clk` rises, so it rises in phase with the main clocks.
- R6: With `pll_on` = 0, `dbl_clk` equals the inverse of the selected reference, with no dependence on the oscillator.
- R7: With `pll_on` = 0, after release `main_clk` and `half_clk` stay low and `inv_clk` stays high until the first falling edge of the selected reference. After that, `main_clk` toggles on every falling reference edge and `half_clk` toggles on every rising `main_clk` edge.
- R8: Driving `oe_rst_n` low clears every enable bit and sets `main_clk` and `half_clk` to 0 at once, without waiting for a clock edge.
- R9: While `oe_rst_n` is high, every enable bit (`main_oe`, `inv_oe`, `dbl_oe`, `half_oe`) is 1.
- R10: `lock_out` equals `lock_in` whatever the state of `oe_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock |
| ref_clk0 | input | 1 | Reference clock 0 |
| ref_clk1 | input | 1 | Reference clock 1 |
| ref_sel | input | 1 | Reference choice (0: ref_clk0, 1: ref_clk1) |
| pll_on | input | 1 | 1: oscillator drives the tree; 0: bypass, the selected reference drives it |
| prediv_en | input | 1 | 1: extra divide-by-two ahead of the tree |
| oe_rst_n | input | 1 | Active-low asynchronous output disable and divider reset |
| lock_in | input | 1 | Lock flag from the external detector |
| main_clk | output | NUM_MAIN | Main clocks, all identical |
| main_oe | output | NUM_MAIN | Drive enables of the main clocks |
| inv_clk | output | 1 | Inverted main clock |
| inv_oe | output | 1 | Drive enable of inv_clk |
| dbl_clk | output | 1 | Double-rate clock |
| dbl_oe | output | 1 | Drive enable of dbl_clk |
| half_clk | output | 1 | Half-rate clock |
| half_oe | output | 1 | Drive enable of half_clk |
| lock_out | output | 1 | Lock flag, never disabled |

## Verification
In oscillator mode, every divided output settles in the same time step as the osc rising edge that moves it. The divider is a ripple chain, and no pipeline register sits between a stage and its pin. In bypass mode, the outputs settle on the reference edge itself. The enables, the asynchronous clear and the lock flag take effect with no clock at all. The bench counts osc rising edges and falling edges of the selected reference since release and derives the expected levels from those counts. It samples 2.6 ns after each osc rising edge, a point that no reference edge ever hits. It probes the asynchronous clear 0.5 ns after dropping `oe_rst_n`, well before the next edge of any clock.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Phase of the main/half pair; encoding is {half, main}
    typedef enum logic [1:0] {
        PH_IDLE    = 2'b00,
        PH_MAIN_HI = 2'b01,
        PH_HALF_HI = 2'b10,
        PH_BOTH_HI = 2'b11
    } phase_t;

endpackage

// File: rtl/clkdiv_ref_mux.sv
module clkdiv_ref_mux #(
    parameter int NUM_REF = 2,
    localparam int SEL_W  = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
    input  logic [NUM_REF-1:0] ref_clk,
    input  logic [SEL_W-1:0]   ref_sel,
    output logic               sel_ref
);

    // R1: plain index select of the reference inputs
    always_comb begin
        sel_ref = 1'b0;
        for (int i = 0; i < NUM_REF; i++) begin
            if (ref_sel == SEL_W'(i)) sel_ref = ref_clk[i];
        end
    end

endmodule

// File: rtl/clkdiv_prescale.sv
module clkdiv_prescale (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic pll_on,
    input  logic prediv_en,
    input  logic sel_ref,
    output logic tree_clk
);

    logic pre_q;
    logic head_clk;
    logic dbl_q;

    // Optional divide-by-two ahead of the tree (R3)
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) pre_q <= 1'b0;
        else        pre_q <= ~pre_q;
    end

    always_comb head_clk = prediv_en ? pre_q : osc_clk;

    // Double-rate stage
    always_ff @(posedge head_clk or negedge rst_n) begin
        if (!rst_n) dbl_q <= 1'b0;
        else        dbl_q <= ~dbl_q;
    end

    // Bypass: inverted reference takes the place of the double-rate node (R6)
    always_comb tree_clk = pll_on ? dbl_q : ~sel_ref;

    // R3: with the pre-divider on, the double-rate node holds for two osc edges
    a_r3_dbl_two_edges: assert property (@(posedge osc_clk)
        disable iff (!rst_n || !pll_on || !prediv_en)
        $changed(tree_clk) |=> $stable(tree_clk));

endmodule

// File: rtl/clkdiv_phase_fsm.sv
module clkdiv_phase_fsm
    import clkdiv_pkg::*;
(
    input  logic tree_clk,
    input  logic rst_n,
    output logic main_q,
    output logic half_q
);

    phase_t state_q;
    phase_t state_d;

    // State register
    always_ff @(posedge tree_clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: IDLE -> BOTH_HI -> HALF_HI -> MAIN_HI -> IDLE
    always_comb begin
        unique case (state_q)
            PH_IDLE:    state_d = PH_BOTH_HI;
            PH_BOTH_HI: state_d = PH_HALF_HI;
            PH_HALF_HI: state_d = PH_MAIN_HI;
            PH_MAIN_HI: state_d = PH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            PH_IDLE:    begin main_q = 1'b0; half_q = 1'b0; end
            PH_BOTH_HI: begin main_q = 1'b1; half_q = 1'b1; end
            PH_HALF_HI: begin main_q = 1'b0; half_q = 1'b1; end
            PH_MAIN_HI: begin main_q = 1'b1; half_q = 1'b0; end
        endcase
    end

endmodule

// File: rtl/clk_fanout_divider.sv
module clk_fanout_divider #(
    parameter int NUM_MAIN = 5
) (
    input  logic                osc_clk,
    input  logic                ref_clk0,
    input  logic                ref_clk1,
    input  logic                ref_sel,
    input  logic                pll_on,
    input  logic                prediv_en,
    input  logic                oe_rst_n,
    input  logic                lock_in,
    output logic [NUM_MAIN-1:0] main_clk,
    output logic [NUM_MAIN-1:0] main_oe,
    output logic                inv_clk,
    output logic                inv_oe,
    output logic                dbl_clk,
    output logic                dbl_oe,
    output logic                half_clk,
    output logic                half_oe,
    output logic                lock_out
);

    localparam int REF_COUNT = 2;

    logic sel_ref;
    logic tree_clk;
    logic main_q;
    logic half_q;

    clkdiv_ref_mux #(.NUM_REF(REF_COUNT)) u_refmux (
        .ref_clk ({ref_clk1, ref_clk0}),
        .ref_sel (ref_sel),
        .sel_ref (sel_ref)
    );

    clkdiv_prescale u_pre (
        .osc_clk   (osc_clk),
        .rst_n     (oe_rst_n),
        .pll_on    (pll_on),
        .prediv_en (prediv_en),
        .sel_ref   (sel_ref),
        .tree_clk  (tree_clk)
    );

    clkdiv_phase_fsm u_phase (
        .tree_clk (tree_clk),
        .rst_n    (oe_rst_n),
        .main_q   (main_q),
        .half_q   (half_q)
    );

    // Fan-out of the single main register (R4), enables per output (R8, R9)
    for (genvar g = 0; g < NUM_MAIN; g++) begin : g_main
        assign main_clk[g] = main_q;
        assign main_oe[g]  = oe_rst_n;
    end

    assign inv_clk  = ~main_q;
    assign inv_oe   = oe_rst_n;
    assign dbl_clk  = tree_clk;
    assign dbl_oe   = oe_rst_n;
    assign half_clk = half_q;
    assign half_oe  = oe_rst_n;
    assign lock_out = lock_in;   // R10

    // R5: half-rate output moves only with a rising main edge
    a_r5_half_in_phase: assert property (@(posedge osc_clk)
        disable iff (!oe_rst_n)
        $changed(half_clk) |-> $rose(main_clk[0]));

    // R2: a rising main edge always comes with a rising double-rate edge
    a_r2_main_with_dbl: assert property (@(posedge osc_clk)
        disable iff (!oe_rst_n)
        $rose(main_clk[0]) |-> $rose(dbl_clk));

    // R2: without pre-divider, main holds for two osc edges
    a_r2_main_two_edges: assert property (@(posedge osc_clk)
        disable iff (!oe_rst_n || !pll_on || prediv_en)
        $changed(main_clk[0]) |=> $stable(main_clk[0]));

endmodule

// File: tb/sim_clk_fanout_divider.sv
`timescale 1ns/1ps
module sim_clk_fanout_divider;

    localparam int NM = 5;

    logic osc_clk = 1'b0;
    logic ref_clk0 = 1'b0;
    logic ref_clk1 = 1'b0;
    logic ref_sel = 1'b0;
    logic pll_on = 1'b1;
    logic prediv_en = 1'b0;
    logic oe_rst_n = 1'b0;
    logic lock_in = 1'b0;
    logic [NM-1:0] main_clk, main_oe;
    logic inv_clk, inv_oe, dbl_clk, dbl_oe, half_clk, half_oe, lock_out;

    int checks = 0;
    int errors = 0;
    int c_osc = 0;
    int c_fall = 0;
    logic sel_ref_b;

    clk_fanout_divider #(.NUM_MAIN(NM)) u0 (
        .osc_clk(osc_clk), .ref_clk0(ref_clk0), .ref_clk1(ref_clk1),
        .ref_sel(ref_sel), .pll_on(pll_on), .prediv_en(prediv_en),
        .oe_rst_n(oe_rst_n), .lock_in(lock_in),
        .main_clk(main_clk), .main_oe(main_oe),
        .inv_clk(inv_clk), .inv_oe(inv_oe),
        .dbl_clk(dbl_clk), .dbl_oe(dbl_oe),
        .half_clk(half_clk), .half_oe(half_oe),
        .lock_out(lock_out)
    );

    // 100 MHz oscillator; references toggle at times ending in 2 ns
    always #5 osc_clk = ~osc_clk;
    initial begin #2; forever #20 ref_clk0 = ~ref_clk0; end
    initial begin #2; forever #30 ref_clk1 = ~ref_clk1; end

    assign sel_ref_b = ref_sel ? ref_clk1 : ref_clk0;

    always @(posedge osc_clk) if (oe_rst_n) c_osc++;
    always @(negedge sel_ref_b) if (oe_rst_n) c_fall++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d",
                     req, what, $time, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic sample();
        int v;
        logic em, eh, ed;
        string tm, td;
        if (!oe_rst_n) begin
            em = 1'b0; eh = 1'b0; ed = pll_on ? 1'b0 : ~sel_ref_b;
            tm = "R8"; td = pll_on ? "R8" : "R6";
        end else if (!pll_on) begin
            v = (4 - c_fall % 4) % 4;
            em = v[0]; eh = v[1]; ed = ~sel_ref_b;
            tm = "R7"; td = ref_sel ? "R1" : "R6";
        end else if (!prediv_en) begin
            v = (8 - c_osc % 8) % 8;
            ed = v[0]; em = v[1]; eh = v[2];
            tm = "R2"; td = "R2";
        end else begin
            v = (16 - c_osc % 16) % 16;
            ed = v[1]; em = v[2]; eh = v[3];
            tm = "R3"; td = "R3";
        end
        chk(main_clk == {NM{em}}, "R4", "main_clk bits", int'(main_clk), em ? (1 << NM) - 1 : 0);
        chk(main_clk[0] == em, tm, "main_clk", int'(main_clk[0]), int'(em));
        chk(inv_clk == ~em, "R4", "inv_clk", int'(inv_clk), int'(~em));
        chk(half_clk == eh, (oe_rst_n && pll_on) ? "R5" : tm, "half_clk", int'(half_clk), int'(eh));
        chk(dbl_clk == ed, td, "dbl_clk", int'(dbl_clk), int'(ed));
        chk({main_oe, inv_oe, dbl_oe, half_oe} == {(NM+3){oe_rst_n}},
            oe_rst_n ? "R9" : "R8", "enables",
            int'({main_oe, inv_oe, dbl_oe, half_oe}), oe_rst_n ? (1 << (NM+3)) - 1 : 0);
        chk(lock_out == lock_in, "R10", "lock_out", int'(lock_out), int'(lock_in));
    endtask

    task automatic run_mode(input logic pll, input logic pre, input logic sel, input int n);
        logic was_on;
        was_on = oe_rst_n;
        oe_rst_n = 1'b0;
        #0.5;
        if (was_on) begin
            // R8: asynchronous clear, observed before any clock edge
            chk(main_clk == '0 && half_clk == 1'b0, "R8", "async clear",
                int'({main_clk, half_clk}), 0);
            chk({main_oe, inv_oe, dbl_oe, half_oe} == '0, "R8", "async disable",
                int'({main_oe, inv_oe, dbl_oe, half_oe}), 0);
        end
        @(posedge osc_clk); #1;
        pll_on = pll; prediv_en = pre; ref_sel = sel;
        for (int k = 0; k < 4; k++) begin
            @(posedge osc_clk); #2.5;
            lock_in = ~lock_in;   // R10 while disabled
            #0.1;
            sample();
        end
        @(posedge osc_clk); #1;
        c_osc = 0; c_fall = 0;
        oe_rst_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(posedge osc_clk); #2.5;
            if (k % 3 == 0) lock_in = ~lock_in;
            #0.1;
            sample();
        end
    endtask

    initial begin
        #0.5;
        sample();                 // reset state
        run_mode(1'b1, 1'b0, 1'b0, 40);   // R2
        run_mode(1'b1, 1'b1, 1'b0, 48);   // R3
        run_mode(1'b0, 1'b0, 1'b0, 40);   // R6, R7 on ref 0
        run_mode(1'b0, 1'b0, 1'b1, 50);   // R1, R7 on ref 1
        run_mode(1'b1, 1'b0, 1'b1, 20);   // R2 again, R8 mid-run
        summary();
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule